// File: doc/BRIEF.md
# External Bus Write Cycle Sequencer

This block turns single write requests from an internal port into write cycles on an external asynchronous memory bus. It runs from a timing clock and reports, on every timing cycle, whether that cycle opens a rising edge of the bus clock. The bus clock runs either at the timing clock rate or at half of it. Each write goes through a lead phase, then an active phase, then a trail phase. Each phase length is set by its own configuration field and counted in timing-clock cycles. Chip select and the direction line fall at the start of lead. The write strobes are low for the whole active phase. The data bus is driven from the start of active until the end of trail.

A requester holds `req_valid` with a stable address, data word and half-word enables until `req_ack` pulses. In half-rate mode the lead phase must open on a bus clock rising edge. When a request lands on the wrong edge, the block first spends one alignment cycle with every control line inactive. Between accesses the address outputs keep the last address driven, except bit 0, which reads high. A ready input can stretch the active phase when it is enabled. In 16-bit mode the upper strobe pin carries address bit 0 instead.

The configuration inputs are expected to stay stable while a write is in progress. `rst_n` is assumed to be already synchronised to `clk`.

Top module: `ebus_wr_seq`

## Requirements
- R1: A write runs lead, then active, then trail, with no gaps. `bus_cs_n` and `bus_rnw` are 0 in all three phases and 1 otherwise. The lead phase lasts `cfg_lead` cycles, and a value of 0 is treated as 1.
- R2: The active phase lasts `cfg_active`+1 cycles when ready extension adds nothing. The trail phase lasts `cfg_trail`+1 cycles. `bus_we0_n` is 0 only in active cycles, and only when `req_be[0]` was 1.
- R3: `bus_ck_rise` is 1 on every cycle in full-rate mode (`cfg_half_rate`=0). In half-rate mode it alternates and is 1 on the first cycle after reset. The first lead cycle always has `bus_ck_rise`=1. In half-rate mode, a request accepted in a cycle with `bus_ck_rise`=1 gets exactly one alignment cycle before lead. Full-rate mode never inserts one.
- R4: During an alignment cycle, `bus_cs_n`, `bus_rnw`, `bus_we0_n` and `bus_we1_n` are 1 and `bus_data_oe` is 0.
- R5: Outside lead, active and trail (including alignment), `bus_addr` shows the last written address with bit 0 forced to 1. After reset it reads 20'h00001. Inside a write it shows `req_addr` as captured.
- R6: When `cfg_wide`=1, `bus_we1_n` is 0 only in active cycles and only when `req_be[1]` was 1. When `cfg_wide`=0, `bus_we1_n` equals `bus_addr[0]`, and `bus_data_o[31:16]` is 0.
- R7: When `cfg_use_rdy`=0, `bus_rdy` has no effect on phase lengths or pins.
- R8: When `cfg_use_rdy`=1, each cycle in which the programmed active count has run out and `bus_rdy` is 0 adds one more active cycle.
- R9: `bus_data_oe` is 1 exactly in active and trail cycles, and never while `bus_rnw` is 1. `bus_data_o` carries the captured data while enabled and is 0 otherwise.
- R10: `req_ack` is a one-cycle pulse in the cycle after the last trail cycle. A request is accepted only from idle in a cycle where `req_ack` is 0.
- R11: In reset, `bus_cs_n`, `bus_rnw`, `bus_we0_n` and `bus_we1_n` are 1, `bus_data_oe` and `req_ack` are 0, and `bus_addr` is 20'h00001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_half_rate | input | 1 | 1: bus clock is half the timing clock |
| cfg_wide | input | 1 | 1: 32-bit data bus, 0: 16-bit |
| cfg_use_rdy | input | 1 | 1: bus_rdy may stretch the active phase |
| cfg_lead | input | 4 | Lead length in cycles (0 treated as 1) |
| cfg_active | input | 4 | Extra active cycles |
| cfg_trail | input | 4 | Extra trail cycles |
| req_valid | input | 1 | Write request pending |
| req_addr | input | 20 | Write address |
| req_data | input | 32 | Write data |
| req_be | input | 2 | Half-word enables (bit 0 low half, bit 1 high half) |
| req_ack | output | 1 | One-cycle completion pulse |
| bus_ck_rise | output | 1 | This cycle opens a bus clock rising edge |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_addr | output | 20 | Address bus |
| bus_rnw | output | 1 | Direction, 0 during a write |
| bus_we0_n | output | 1 | Low-half write strobe, active low |
| bus_we1_n | output | 1 | High-half strobe (32-bit) or address bit 0 (16-bit) |
| bus_data_o | output | 32 | Data bus output value |
| bus_data_oe | output | 1 | Data bus output enable |
| bus_rdy | input | 1 | External ready |

## Verification
On every cycle, the assertions check these properties:
- lead always opens on a bus clock rising edge;
- an alignment cycle keeps every control line inactive;
- the data enable never overlaps a high direction line;
- the idle address always has bit 0 set;
- trail only ever follows active;
- the acknowledge never lasts two cycles;
- a low ready at the end of the active count holds the active phase.

Exact phase lengths, including lead 0 counted as one cycle, can only be shown by the bench's scenarios. The same holds for when alignment is inserted across back-to-back requests in half-rate mode, for ready being ignored when it is not enabled, and for the reuse of the strobe pin as an address bit in 16-bit mode.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ALIGN = 3'd1,
    ST_LEAD  = 3'd2,
    ST_ACT   = 3'd3,
    ST_TRL   = 3'd4
  } bus_st_e;
endpackage

// File: rtl/ebus_clk_phase.sv
module ebus_clk_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic half_i,
  output logic rise_o,
  output logic next_rise_o
);
  logic ph_q, ph_d;

  always_comb ph_d = ~ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  // In half-rate mode a rising edge opens every cycle where the phase bit is 1.
  assign rise_o      = half_i ? ph_q : 1'b1;
  assign next_rise_o = half_i ? ph_d : 1'b1;

  AST_RISE_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    (half_i && $past(half_i) && $past(rst_n)) |-> (rise_o != $past(rise_o))); // R3
endmodule

// File: rtl/ebus_wr_fsm.sv
module ebus_wr_fsm
  import ebus_pkg::*;
#(
  parameter int LEAD_W = 4,
  parameter int ACT_W  = 4,
  parameter int TRL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              use_rdy_i,
  input  logic [LEAD_W-1:0] lead_i,
  input  logic [ACT_W-1:0]  act_i,
  input  logic [TRL_W-1:0]  trl_i,
  input  logic              req_valid_i,
  input  logic              next_rise_i,
  input  logic              rdy_i,
  output bus_st_e           st_o,
  output logic              accept_o,
  output logic              ack_o
);
  localparam int CW0   = (LEAD_W > ACT_W) ? LEAD_W : ACT_W;
  localparam int CNT_W = (CW0 > TRL_W) ? CW0 : TRL_W;

  bus_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             ack_q, ack_d;
  logic [CNT_W-1:0] lead_load, act_load, trl_load;
  logic             cnt_zero;

  always_comb begin
    lead_load = (lead_i == '0) ? '0 : CNT_W'(lead_i - 1'b1);
    act_load  = CNT_W'(act_i);
    trl_load  = CNT_W'(trl_i);
    cnt_zero  = (cnt_q == '0);
  end

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    ack_d    = 1'b0;
    accept_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid_i && !ack_q) begin
          accept_o = 1'b1;
          if (next_rise_i) begin
            st_d   = ST_LEAD;
            cnt_d  = lead_load;
            cnt_en = 1'b1;
          end else begin
            st_d = ST_ALIGN;
          end
        end
      end
      ST_ALIGN: begin
        st_d   = ST_LEAD;
        cnt_d  = lead_load;
        cnt_en = 1'b1;
      end
      ST_LEAD: begin
        cnt_en = 1'b1;
        if (cnt_zero) begin
          st_d  = ST_ACT;
          cnt_d = act_load;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_ACT: begin
        if (!cnt_zero) begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q - 1'b1;
        end else if (use_rdy_i && !rdy_i) begin
          st_d = ST_ACT;
        end else begin
          st_d   = ST_TRL;
          cnt_d  = trl_load;
          cnt_en = 1'b1;
        end
      end
      ST_TRL: begin
        cnt_en = 1'b1;
        if (cnt_zero) begin
          st_d  = ST_IDLE;
          ack_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ack_q <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign st_o  = st_q;
  assign ack_o = ack_q;

  AST_TRAIL_AFTER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TRL && $past(st_q) != ST_TRL) |-> ($past(st_q) == ST_ACT)); // R1
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q); // R10
  AST_RDY_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACT && cnt_zero && use_rdy_i && !rdy_i) |=> (st_q == ST_ACT)); // R8
endmodule

// File: rtl/ebus_pin_drv.sv
module ebus_pin_drv
  import ebus_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bus_st_e       st_i,
  input  logic          accept_i,
  input  logic          wide_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_data_i,
  input  logic [1:0]    req_be_i,
  output logic          cs_n_o,
  output logic [AW-1:0] addr_o,
  output logic          rnw_o,
  output logic          we0_n_o,
  output logic          we1_n_o,
  output logic [DW-1:0] data_o,
  output logic          oe_o
);
  localparam int HW = DW / 2;

  logic [AW-1:0] cap_addr_q, last_addr_q;
  logic [DW-1:0] cap_data_q, data_masked;
  logic [1:0]    cap_be_q;
  logic          in_cycle, in_act, drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr_q <= '0;
      cap_data_q <= '0;
      cap_be_q   <= '0;
    end else if (accept_i) begin
      cap_addr_q <= req_addr_i;
      cap_data_q <= req_data_i;
      cap_be_q   <= req_be_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                last_addr_q <= '0;
    else if (st_i == ST_LEAD)  last_addr_q <= cap_addr_q;
  end

  always_comb begin
    in_cycle = (st_i == ST_LEAD) || (st_i == ST_ACT) || (st_i == ST_TRL);
    in_act   = (st_i == ST_ACT);
    drive    = in_act || (st_i == ST_TRL);
    data_masked = wide_i ? cap_data_q : {{(DW-HW){1'b0}}, cap_data_q[HW-1:0]};
  end

  assign cs_n_o  = ~in_cycle;
  assign rnw_o   = ~in_cycle;
  assign addr_o  = in_cycle ? cap_addr_q : {last_addr_q[AW-1:1], 1'b1};
  assign we0_n_o = ~(in_act && cap_be_q[0]);
  assign we1_n_o = wide_i ? ~(in_act && cap_be_q[1]) : addr_o[0];
  assign oe_o    = drive;
  assign data_o  = drive ? data_masked : '0;

  AST_ALIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_i == ST_ALIGN) |-> (cs_n_o && rnw_o && we0_n_o && we1_n_o && !oe_o)); // R4
  AST_OE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    oe_o |-> !rnw_o); // R9
  AST_IDLE_ADDR0_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> addr_o[0]); // R5
endmodule

// File: rtl/ebus_wr_seq.sv
module ebus_wr_seq
  import ebus_pkg::*;
#(
  parameter int AW     = 20,
  parameter int DW     = 32,
  parameter int LEAD_W = 4,
  parameter int ACT_W  = 4,
  parameter int TRL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_half_rate,
  input  logic              cfg_wide,
  input  logic              cfg_use_rdy,
  input  logic [LEAD_W-1:0] cfg_lead,
  input  logic [ACT_W-1:0]  cfg_active,
  input  logic [TRL_W-1:0]  cfg_trail,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_data,
  input  logic [1:0]        req_be,
  output logic              req_ack,
  output logic              bus_ck_rise,
  output logic              bus_cs_n,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_rnw,
  output logic              bus_we0_n,
  output logic              bus_we1_n,
  output logic [DW-1:0]     bus_data_o,
  output logic              bus_data_oe,
  input  logic              bus_rdy
);
  bus_st_e st;
  logic    accept, next_rise;

  ebus_clk_phase u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .half_i      (cfg_half_rate),
    .rise_o      (bus_ck_rise),
    .next_rise_o (next_rise)
  );

  ebus_wr_fsm #(.LEAD_W(LEAD_W), .ACT_W(ACT_W), .TRL_W(TRL_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .use_rdy_i   (cfg_use_rdy),
    .lead_i      (cfg_lead),
    .act_i       (cfg_active),
    .trl_i       (cfg_trail),
    .req_valid_i (req_valid),
    .next_rise_i (next_rise),
    .rdy_i       (bus_rdy),
    .st_o        (st),
    .accept_o    (accept),
    .ack_o       (req_ack)
  );

  ebus_pin_drv #(.AW(AW), .DW(DW)) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_i       (st),
    .accept_i   (accept),
    .wide_i     (cfg_wide),
    .req_addr_i (req_addr),
    .req_data_i (req_data),
    .req_be_i   (req_be),
    .cs_n_o     (bus_cs_n),
    .addr_o     (bus_addr),
    .rnw_o      (bus_rnw),
    .we0_n_o    (bus_we0_n),
    .we1_n_o    (bus_we1_n),
    .data_o     (bus_data_o),
    .oe_o       (bus_data_oe)
  );

  AST_LEAD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LEAD && $past(st) != ST_LEAD) |-> bus_ck_rise); // R3
endmodule

// File: tb/ebus_wr_seq_tb.sv
module ebus_wr_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_half_rate = 1'b0, cfg_wide = 1'b1, cfg_use_rdy = 1'b0;
  logic [3:0]  cfg_lead = 4'd1, cfg_active = 4'd0, cfg_trail = 4'd0;
  logic        req_valid = 1'b0;
  logic [19:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic [1:0]  req_be = '0;
  logic        req_ack, bus_ck_rise, bus_cs_n, bus_rnw, bus_we0_n, bus_we1_n, bus_data_oe;
  logic [19:0] bus_addr;
  logic [31:0] bus_data_o;
  logic        bus_rdy = 1'b1;

  always #4 clk = ~clk;

  ebus_wr_seq dut_i (.*);

  typedef struct {
    bit cs_n, rnw, we0_n, we1_n, oe, ack, rdy, idle;
    bit [19:0] addr;
    bit [31:0] data;
  } frm_t;
  typedef struct {
    bit [19:0] a;
    bit [31:0] d;
    bit [1:0]  be;
    int        k;
  } rq_t;

  frm_t exq[$];
  rq_t  rq[$];
  int   checks = 0, errors = 0;
  bit   mph = 1'b0, busy_m = 1'b0, done = 1'b0;
  bit [19:0] m_last = '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic frm_t idle_frm(input bit [19:0] last, input bit ack, input bit idle);
    frm_t f;
    f.cs_n = 1; f.rnw = 1; f.we0_n = 1; f.oe = 0; f.ack = ack; f.rdy = 1; f.idle = idle;
    f.addr = {last[19:1], 1'b1}; f.data = '0;
    f.we1_n = cfg_wide ? 1'b1 : f.addr[0];
    return f;
  endfunction

  task automatic push_write(input rq_t r);
    int   nl, na, nt, ext;
    frm_t f;
    bit [31:0] dv;
    nl  = (cfg_lead == 0) ? 1 : int'(cfg_lead);
    na  = int'(cfg_active) + 1;
    nt  = int'(cfg_trail) + 1;
    ext = cfg_use_rdy ? r.k : 0;
    dv  = cfg_wide ? r.d : {16'h0, r.d[15:0]};
    if (cfg_half_rate && mph) exq.push_back(idle_frm(m_last, 0, 0));
    f.cs_n = 0; f.rnw = 0; f.ack = 0; f.idle = 0; f.addr = r.a; f.rdy = 1;
    for (int i = 0; i < nl; i++) begin
      f.we0_n = 1; f.we1_n = cfg_wide ? 1'b1 : r.a[0]; f.oe = 0; f.data = '0;
      exq.push_back(f);
    end
    for (int i = 0; i < na + ext; i++) begin
      f.we0_n = ~r.be[0]; f.we1_n = cfg_wide ? ~r.be[1] : r.a[0]; f.oe = 1; f.data = dv;
      f.rdy = !(i >= na - 1 && i < na - 1 + r.k);
      exq.push_back(f);
    end
    f.rdy = 1;
    for (int i = 0; i < nt; i++) begin
      f.we0_n = 1; f.we1_n = cfg_wide ? 1'b1 : r.a[0]; f.oe = 1; f.data = dv;
      exq.push_back(f);
    end
    exq.push_back(idle_frm(r.a, 1, 1));
    m_last = r.a;
  endtask

  // Reference model, compared on every cycle
  initial begin
    frm_t e;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      mph = ~mph;
      if (exq.size() > 0) e = exq.pop_front();
      else                e = idle_frm(m_last, 0, 1);
      chk(bus_cs_n == e.cs_n, "R1 cs_n", bus_cs_n, e.cs_n);
      chk(bus_rnw == e.rnw, "R1 rnw", bus_rnw, e.rnw);
      chk(bus_we0_n == e.we0_n, "R2 we0_n", bus_we0_n, e.we0_n);
      chk(bus_we1_n == e.we1_n, "R6 we1_n", bus_we1_n, e.we1_n);
      chk(bus_data_oe == e.oe, "R9 oe", bus_data_oe, e.oe);
      chk(bus_data_o == e.data, "R9 data", bus_data_o, e.data);
      chk(bus_addr == e.addr, "R5 addr", bus_addr, e.addr);
      chk(req_ack == e.ack, "R10 ack", req_ack, e.ack);
      chk(bus_ck_rise == (cfg_half_rate ? mph : 1'b1), "R3 rise", bus_ck_rise, cfg_half_rate ? mph : 1'b1);
      bus_rdy = e.rdy;
      if (e.ack) begin
        req_valid = 0; busy_m = 0;
        void'(rq.pop_front());
      end else if (!req_valid && rq.size() > 0) begin
        req_valid = 1; req_addr = rq[0].a; req_data = rq[0].d; req_be = rq[0].be;
      end
      if (e.idle && !e.ack && req_valid && !busy_m) begin
        busy_m = 1;
        push_write(rq[0]);
      end
    end
  end

  task automatic cfg_set(input bit half, input bit wide, input bit ur,
                         input bit [3:0] l, input bit [3:0] a, input bit [3:0] t);
    @(posedge clk); #1;
    cfg_half_rate = half; cfg_wide = wide; cfg_use_rdy = ur;
    cfg_lead = l; cfg_active = a; cfg_trail = t;
  endtask

  task automatic wr(input bit [19:0] a, input bit [31:0] d, input bit [1:0] be, input int k);
    rq_t r;
    r.a = a; r.d = d; r.be = be; r.k = k;
    rq.push_back(r);
  endtask

  task automatic drain();
    @(posedge clk);
    while (rq.size() > 0 || exq.size() > 0 || req_valid) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R11 reset state
    chk(bus_cs_n && bus_rnw && bus_we0_n && bus_we1_n, "R11 ctrl", {bus_cs_n, bus_rnw, bus_we0_n, bus_we1_n}, 4'hF);
    chk(!bus_data_oe && !req_ack, "R11 oe/ack", {bus_data_oe, req_ack}, 0);
    chk(bus_addr == 20'h00001, "R11 addr", bus_addr, 20'h00001);
    @(negedge clk);
    rst_n = 1;
    // R1 R2 minimum lengths, full rate
    cfg_set(0, 1, 0, 4'd1, 4'd0, 4'd0);
    wr(20'h12344, 32'hA5A5_0F0F, 2'b11, 0);
    drain();
    // R1 lead 0 treated as 1; longer phases; R2 single low strobe
    cfg_set(0, 1, 0, 4'd0, 4'd3, 4'd2);
    wr(20'hABCDE, 32'h1357_9BDF, 2'b01, 0);
    wr(20'h00010, 32'hFFFF_0000, 2'b10, 0);
    drain();
    // R3 R4 half rate, back-to-back, odd lengths force alignment
    cfg_set(1, 1, 0, 4'd2, 4'd1, 4'd0);
    wr(20'h55554, 32'hDEAD_BEEF, 2'b11, 0);
    wr(20'h22222, 32'hCAFE_F00D, 2'b11, 0);
    wr(20'h33332, 32'h0BAD_C0DE, 2'b01, 0);
    drain();
    cfg_set(1, 1, 0, 4'd3, 4'd2, 4'd1);
    wr(20'h40001, 32'h0000_1111, 2'b11, 0);
    wr(20'h40002, 32'h2222_0000, 2'b10, 0);
    drain();
    // R6 16-bit mode: strobe pin carries address bit 0, upper data zero
    cfg_set(0, 0, 0, 4'd1, 4'd1, 4'd1);
    wr(20'h70000, 32'h9999_ABCD, 2'b01, 0);
    wr(20'h70003, 32'h8888_1234, 2'b11, 0);
    drain();
    // R7 ready low while not enabled has no effect
    cfg_set(0, 1, 0, 4'd1, 4'd2, 4'd0);
    wr(20'h0F0F0, 32'h7777_6666, 2'b11, 3);
    drain();
    // R8 ready enabled: extension by low cycles, and none when ready high
    cfg_set(0, 1, 1, 4'd1, 4'd2, 4'd1);
    wr(20'h0A0A0, 32'h5555_4444, 2'b11, 3);
    wr(20'h0B0B0, 32'h3333_2222, 2'b11, 0);
    drain();
    cfg_set(1, 0, 1, 4'd1, 4'd0, 4'd0);
    wr(20'h0C0C1, 32'h0000_AAAA, 2'b01, 2);
    drain();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule